// File: doc/BRIEF.md
# Reference-Selectable Feedback Divider with Phase Lock Detector

This block is the digital half of a clock-synthesis loop. It runs entirely on the fast synthesized clock. It divides that clock by a ratio picked with a 3-bit reference select, which gives a feedback clock at the chosen reference frequency. At every rising edge of the already-sampled reference clock, it measures how far that edge sits from the nearest rising edge of the feedback clock, counted in fast-clock cycles.

A lock flag is raised once the measured phase error has stayed inside one eighth of the feedback period for a run of comparisons. It is dropped again after a shorter run of comparisons outside that window. If the select changes, or holds an unsupported code, the divider and both run counters restart and the lock flag is cleared. The analog parts of the loop sit outside this block: phase detector output, charge pump, loop filter and oscillator.

Top module: `refsel_fbdiv_lock`

## Requirements
- R1: The select code sets the divide ratio N: 000→128, 001→64, 010→48, 011→32, 101→16, 110→8, 111→4. The feedback clock repeats every N cycles. It is high for the first N/2 cycles of each period, and its rising cycle is the one in which the internal phase count is 0.
- R2: Select code 100 is invalid. While it is applied, the feedback clock is held low, the lock flag is low and no phase measurement is reported.
- R3: Any cycle in which the applied select differs from the registered select, or is invalid, is a restart cycle. In the cycle after a restart the feedback clock starts a new period (phase count 0, clock high), and the lock flag is low.
- R4: A reference rising edge is a cycle with `ref_in` = 1 where the previous cycle had 0. In the next cycle `phase_valid` is high for exactly one cycle.
- R5: `phase_err` is two's complement with the width of the ratio. With c the phase count in the edge cycle, it reports c when c < N/2 and c − N otherwise, so it lies in [−N/2, N/2−1].
- R6: A measurement is in window when 8·|phase_err| < N, for example |err| ≤ 15 for N = 128 and only err = 0 for N = 4.
- R7: `lock` rises two cycles after the reference edge that completes 16 consecutive in-window measurements, and it then stays high while measurements remain in window.
- R8: `lock` falls two cycles after the reference edge that completes 4 consecutive out-of-window measurements. An in-window measurement restarts this run, so three misses followed by a hit keep lock high.
- R9: While reset is held, `lock` and `phase_valid` are low, the registered select is 000 and the phase count is 0, so `fb_clk` is high.
- R10: A reference rising edge that falls in a restart cycle is ignored: no `phase_valid` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast synthesized clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sel | input | 3 | Reference frequency select code |
| ref_in | input | 1 | Reference clock, already sampled in the fast domain |
| fb_clk | output | 1 | Divided feedback clock |
| phase_valid | output | 1 | One-cycle pulse marking a new phase measurement |
| phase_err | output | 8 | Signed phase error in fast-clock cycles |
| lock | output | 1 | Active-high phase lock indication |

## Verification
On every cycle, the bound checker confirms several relations. An invalid select clears lock, feedback clock and measurements on the next cycle. A restart always leaves lock low. Every reported error lies within half a period of the active ratio. Lock only rises right after an in-window measurement, and it only falls after a miss or a restart. Some properties depend on counting and can only be shown by the bench's directed scenarios, run against its own cycle model: the exact feedback period for each of the seven ratios, the exact window boundaries (±15 against ±16 at ratio 128, and 0 against 1 at ratio 4), the 16-hit and 4-miss hysteresis counts, and a reference edge dropped during a select change.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int SEL_W = 3;
  localparam int DIV_W = 8;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [DIV_W-1:0] ratio_t;

  typedef struct packed {
    logic   ok;
    ratio_t ratio;
  } div_cfg_t;

  // Map a reference select code to its divide ratio; code 100 is unsupported.
  function automatic div_cfg_t decode_sel(input sel_t code);
    div_cfg_t cfg;
    cfg.ok = 1'b1;
    case (code)
      3'b000:  cfg.ratio = ratio_t'(128);
      3'b001:  cfg.ratio = ratio_t'(64);
      3'b010:  cfg.ratio = ratio_t'(48);
      3'b011:  cfg.ratio = ratio_t'(32);
      3'b101:  cfg.ratio = ratio_t'(16);
      3'b110:  cfg.ratio = ratio_t'(8);
      3'b111:  cfg.ratio = ratio_t'(4);
      default: begin
        cfg.ok    = 1'b0;
        cfg.ratio = '0;
      end
    endcase
    return cfg;
  endfunction

  function automatic logic sel_is_valid(input sel_t code);
    div_cfg_t cfg;
    cfg = decode_sel(code);
    return cfg.ok;
  endfunction

  function automatic ratio_t sel_ratio(input sel_t code);
    div_cfg_t cfg;
    cfg = decode_sel(code);
    return cfg.ratio;
  endfunction
endpackage

// File: rtl/fbdiv_divider.sv
module fbdiv_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cfg_ok,
  input  logic [DIV_W-1:0] ratio,
  output logic [DIV_W-1:0] phase_cnt,
  output logic             fb_clk
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap = (cnt_q == ratio - 1'b1);
    if (restart)   cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign phase_cnt = cnt_q;
  assign fb_clk    = cfg_ok && (cnt_q < (ratio >> 1));
endmodule

// File: rtl/fbdiv_phase_meas.sv
module fbdiv_phase_meas #(
  parameter int DIV_W     = 8,
  parameter int WIN_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             restart,
  input  logic [DIV_W-1:0] phase_cnt,
  input  logic [DIV_W-1:0] ratio,
  output logic             meas_valid,
  output logic [DIV_W-1:0] meas_err,
  output logic             meas_inwin
);
  localparam int MAG_W = DIV_W + WIN_SHIFT;

  logic             ref_q;
  logic             take;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] err_raw;
  logic [DIV_W-1:0] mag;
  logic [MAG_W-1:0] mag_scaled;
  logic [MAG_W-1:0] ratio_ext;
  logic             inwin_raw;

  logic             valid_q, valid_d;
  logic [DIV_W-1:0] err_q, err_d;
  logic             win_q, win_d;

  always_comb begin
    take       = ref_in && !ref_q && !restart;
    half       = ratio >> 1;
    err_raw    = (phase_cnt < half) ? phase_cnt : (phase_cnt - ratio);
    mag        = err_raw[DIV_W-1] ? (~err_raw + 1'b1) : err_raw;
    mag_scaled = {{WIN_SHIFT{1'b0}}, mag} << WIN_SHIFT;
    ratio_ext  = {{WIN_SHIFT{1'b0}}, ratio};
    inwin_raw  = (mag_scaled < ratio_ext);

    valid_d = take;
    err_d   = take ? err_raw   : err_q;
    win_d   = take ? inwin_raw : win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= '0;
      win_q   <= 1'b0;
    end else begin
      ref_q   <= ref_in;
      valid_q <= valid_d;
      err_q   <= err_d;
      win_q   <= win_d;
    end
  end

  assign meas_valid = valid_q;
  assign meas_err   = err_q;
  assign meas_inwin = win_q;
endmodule

// File: rtl/fbdiv_lock_hyst.sv
module fbdiv_lock_hyst #(
  parameter int LOCK_CNT   = 16,
  parameter int UNLOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic meas_valid,
  input  logic meas_inwin,
  output logic lock
);
  localparam int IN_W  = $clog2(LOCK_CNT + 1);
  localparam int OUT_W = $clog2(UNLOCK_CNT + 1);

  logic [IN_W-1:0]  hit_q, hit_d;
  logic [OUT_W-1:0] miss_q, miss_d;
  logic             lock_q, lock_d;

  always_comb begin
    hit_d  = hit_q;
    miss_d = miss_q;
    lock_d = lock_q;
    if (restart) begin
      hit_d  = '0;
      miss_d = '0;
      lock_d = 1'b0;
    end else if (meas_valid) begin
      if (meas_inwin) begin
        miss_d = '0;
        if (hit_q != IN_W'(LOCK_CNT)) hit_d = hit_q + 1'b1;
        if (hit_d == IN_W'(LOCK_CNT)) lock_d = 1'b1;
      end else begin
        hit_d = '0;
        if (miss_q != OUT_W'(UNLOCK_CNT)) miss_d = miss_q + 1'b1;
        if (miss_d == OUT_W'(UNLOCK_CNT)) lock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= '0;
      miss_q <= '0;
      lock_q <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      miss_q <= miss_d;
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;
endmodule

// File: rtl/refsel_fbdiv_lock.sv
module refsel_fbdiv_lock
  import fbdiv_pkg::*;
#(
  parameter int LOCK_CNT   = 16,
  parameter int UNLOCK_CNT = 4,
  parameter int WIN_SHIFT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ref_sel,
  input  logic             ref_in,
  output logic             fb_clk,
  output logic             phase_valid,
  output logic [DIV_W-1:0] phase_err,
  output logic             lock
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_chg;
  logic             in_ok;
  logic             restart;
  div_cfg_t         act_cfg;
  logic [DIV_W-1:0] phase_cnt;
  logic             meas_inwin;

  always_comb begin
    sel_chg = (ref_sel != sel_q);
    in_ok   = sel_is_valid(ref_sel);
    restart = sel_chg || !in_ok;
    sel_d   = sel_chg ? ref_sel : sel_q;
    act_cfg = decode_sel(sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  fbdiv_divider #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .cfg_ok    (act_cfg.ok),
    .ratio     (act_cfg.ratio),
    .phase_cnt (phase_cnt),
    .fb_clk    (fb_clk)
  );

  fbdiv_phase_meas #(.DIV_W(DIV_W), .WIN_SHIFT(WIN_SHIFT)) u_meas (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_in     (ref_in),
    .restart    (restart),
    .phase_cnt  (phase_cnt),
    .ratio      (act_cfg.ratio),
    .meas_valid (phase_valid),
    .meas_err   (phase_err),
    .meas_inwin (meas_inwin)
  );

  fbdiv_lock_hyst #(.LOCK_CNT(LOCK_CNT), .UNLOCK_CNT(UNLOCK_CNT)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .meas_valid (phase_valid),
    .meas_inwin (meas_inwin),
    .lock       (lock)
  );
endmodule

// File: rtl/fbdiv_lock_chk.sv
module fbdiv_lock_chk
  import fbdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] ref_sel,
  input logic [SEL_W-1:0] sel_q,
  input logic             restart,
  input logic             fb_clk,
  input logic             phase_valid,
  input logic [DIV_W-1:0] phase_err,
  input logic             meas_inwin,
  input logic             lock
);
  logic               in_ok;
  logic signed [DIV_W:0] err_s;
  logic signed [DIV_W:0] half_s;
  ratio_t             act_ratio;

  always_comb begin
    in_ok     = sel_is_valid(ref_sel);
    act_ratio = sel_ratio(sel_q);
    err_s     = $signed({phase_err[DIV_W-1], phase_err});
    half_s    = $signed({1'b0, act_ratio >> 1});
  end

  // R2: an unsupported select silences the block on the next cycle
  assert_bad_sel_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ok |=> (!lock && !fb_clk && !phase_valid));

  // R3: a restart always leaves the lock flag low
  assert_restart_unlocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !lock);

  // R4: measurement pulses are single cycles
  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |=> !phase_valid);

  // R5: reported error stays within half a period of the active ratio
  assert_err_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |-> ((err_s >= -half_s) && (err_s < half_s)));

  // R7: lock only rises right after an in-window measurement
  assert_lock_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(phase_valid && meas_inwin));

  // R8: lock only falls after a miss or a restart
  assert_lock_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(restart || (phase_valid && !meas_inwin)));
endmodule

bind refsel_fbdiv_lock fbdiv_lock_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_sel     (ref_sel),
  .sel_q       (sel_q),
  .restart     (restart),
  .fb_clk      (fb_clk),
  .phase_valid (phase_valid),
  .phase_err   (phase_err),
  .meas_inwin  (meas_inwin),
  .lock        (lock)
);

// File: tb/tb_refsel_fbdiv_lock.sv
`timescale 1ns/1ps
module tb_refsel_fbdiv_lock;
  logic       clk;
  logic       rst_n;
  logic [2:0] sel;
  logic       ref_in;
  logic       fb_clk;
  logic       phase_valid;
  logic [7:0] phase_err;
  logic       lock;

  refsel_fbdiv_lock dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_sel     (sel),
    .ref_in      (ref_in),
    .fb_clk      (fb_clk),
    .phase_valid (phase_valid),
    .phase_err   (phase_err),
    .lock        (lock)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench model of the requirements
  int t, cnt, selq_m, valid_t, exp_err, pend_t, inc, outc;
  bit pend_v, exp_lock, m_lock, prev_ref;

  function automatic int ratio_of(input int s);
    case (s)
      0: return 128;
      1: return 64;
      2: return 48;
      3: return 32;
      5: return 16;
      6: return 8;
      7: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0d)", req, what, act, exp, t);
    end
  endtask

  // One cycle: check this cycle's outputs, drive inputs, advance the model.
  task automatic step(input int s, input bit r);
    int nq, c, e, ae;
    bit rs, efb, ev;
    if (pend_t == t) exp_lock = pend_v;
    nq  = ratio_of(selq_m);
    efb = (nq != 0) && (cnt < nq / 2);
    ev  = (valid_t == t);
    check_eq("R1", "fb_clk", int'(fb_clk), int'(efb));
    check_eq("R4", "phase_valid", int'(phase_valid), int'(ev));
    if (ev) check_eq("R5", "phase_err", int'($signed(phase_err)), exp_err);
    check_eq("R7/R8", "lock", int'(lock), int'(exp_lock));
    sel    = s[2:0];
    ref_in = r;
    rs = (s != selq_m) || (ratio_of(s) == 0);
    if (r && !prev_ref && !rs) begin
      c = cnt;
      e = (c < nq / 2) ? c : c - nq;
      valid_t = t + 1;
      exp_err = e;
      ae = (e < 0) ? -e : e;
      if (8 * ae < nq) begin
        outc = 0;
        if (inc < 16) inc++;
        if (inc == 16) m_lock = 1;
      end else begin
        inc = 0;
        if (outc < 4) outc++;
        if (outc == 4) m_lock = 0;
      end
      pend_v = m_lock;
      pend_t = t + 2;
    end
    prev_ref = r;
    if (rs) begin
      cnt = 0; selq_m = s; inc = 0; outc = 0; m_lock = 0;
      pend_v = 0; pend_t = t + 1;
    end else begin
      cnt = (cnt + 1 == nq) ? 0 : cnt + 1;
    end
    t++;
    @(negedge clk);
  endtask

  task automatic idle(input int s, input int k);
    for (int i = 0; i < k; i++) step(s, 1'b0);
  endtask

  // One-cycle reference pulse whenever the phase count equals d
  task automatic run_ref(input int s, input int d, input int nper);
    int n;
    n = ratio_of(s);
    for (int k = 0; k < nper * n; k++) step(s, (cnt == d) && (selq_m == s));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sel = 3'b000; ref_in = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R9", "fb_clk in reset", int'(fb_clk), 1);
    check_eq("R9", "lock in reset", int'(lock), 0);
    check_eq("R9", "phase_valid in reset", int'(phase_valid), 0);
    rst_n = 1'b1;
    t = 0; cnt = 0; selq_m = 0; valid_t = -10; exp_err = 0;
    pend_t = -10; pend_v = 0; exp_lock = 0; m_lock = 0;
    inc = 0; outc = 0; prev_ref = 0;
    idle(0, 140);
  endtask

  task automatic t_divide_all;
    int codes[7] = '{1, 2, 3, 5, 6, 7, 0};
    foreach (codes[i]) begin
      step(codes[i], 1'b0);
      check_eq("R3", "fb_clk high after restart", int'(fb_clk), 1);
      check_eq("R3", "lock low after restart", int'(lock), 0);
      idle(codes[i], 2 * ratio_of(codes[i]) + 2);
    end
  endtask

  task automatic t_lock_hyst;
    run_ref(2, 5, 18); idle(2, 3);
    check_eq("R7", "lock after 16 hits at N=48", int'(lock), 1);
    run_ref(2, 29, 3); idle(2, 3);
    check_eq("R8", "lock held after 3 misses", int'(lock), 1);
    run_ref(2, 5, 1);
    run_ref(2, 29, 3); idle(2, 3);
    check_eq("R8", "lock held after hit resets miss run", int'(lock), 1);
    run_ref(2, 29, 1); idle(2, 3);
    check_eq("R8", "lock dropped after 4 misses", int'(lock), 0);
  endtask

  task automatic t_window;
    run_ref(0, 15, 17); idle(0, 3);
    check_eq("R6", "err +15 at N=128 in window", int'(lock), 1);
    run_ref(0, 16, 4); idle(0, 3);
    check_eq("R6", "err +16 at N=128 out of window", int'(lock), 0);
    run_ref(0, 113, 17); idle(0, 3);
    check_eq("R6", "err -15 at N=128 in window", int'(lock), 1);
    run_ref(0, 112, 4); idle(0, 3);
    check_eq("R6", "err -16 at N=128 out of window", int'(lock), 0);
    run_ref(0, 64, 1); idle(0, 3);
    check_eq("R5", "err -64 reported", int'($signed(phase_err)), -64);
    run_ref(7, 0, 17); idle(7, 3);
    check_eq("R6", "err 0 at N=4 in window", int'(lock), 1);
    run_ref(7, 1, 4); idle(7, 3);
    check_eq("R6", "err 1 at N=4 out of window", int'(lock), 0);
  endtask

  task automatic t_invalid;
    run_ref(3, 2, 18); idle(3, 3);
    check_eq("R7", "lock at N=32", int'(lock), 1);
    for (int k = 0; k < 40; k++) step(4, (k % 8) < 4);
    check_eq("R2", "lock low under code 100", int'(lock), 0);
    check_eq("R2", "fb_clk low under code 100", int'(fb_clk), 0);
    idle(4, 2);
  endtask

  task automatic t_restart_edge;
    run_ref(3, 4, 2);
    step(3, 1'b0);
    step(5, 1'b1);
    check_eq("R10", "edge in restart cycle ignored", int'(phase_valid), 0);
    idle(5, 40);
  endtask

  initial begin
    t_reset();
    t_divide_all();
    t_lock_hyst();
    t_window();
    t_invalid();
    t_restart_edge();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule